// File: doc/BRIEF.md
# Receiver Gain Backoff Controller

This block sets the gain of a receiver front-end amplifier that has no continuous automatic gain control. Each time the receiver is switched on, the controller restores full gain and then runs a single downward search. It waits for a digitized signal-strength sample and tests it against a programmable saturation threshold. If the sample is saturated, the controller drops the gain code by one step and waits a programmable settling time before it accepts another sample. The search ends when a sample falls below the threshold or when saturation is still present at the lowest gain code.

When the search ends, a single-cycle completion pulse is raised. If the search stopped because the lowest gain was reached while the signal was still saturated, a floor flag is set. That flag stays set until the receiver is switched on again. Between searches the gain code is held, and signal-strength samples have no effect.

Top module: `gain_backoff_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `gain_code` is 7 (maximum gain, all ones), `search_done` is 0 and `floor_hit` is 0.
- R2: A rising edge of `rx_en` (high in a cycle, low in the cycle before) starts a search. In the next cycle `gain_code` is 7 and `floor_hit` is 0. A strobe that arrives in the start cycle is not evaluated.
- R3: When the search is waiting for a sample and `rssi_vld` is high with `rssi_data >= cfg_sat_thr` and `gain_code > 0`, `gain_code` is exactly one lower in the next cycle.
- R4: After a gain step, strobes in the following `cfg_settle + 1` cycles are ignored. The first strobe that can be evaluated comes `cfg_settle + 2` cycles after the sample that caused the step.
- R5: An evaluated sample with `rssi_data < cfg_sat_thr` ends the search. `search_done` is high for exactly one cycle, starting in the next cycle, and `gain_code` is unchanged.
- R6: An evaluated saturated sample while `gain_code` is 0 ends the search. `search_done` pulses for one cycle, `gain_code` stays 0, and `floor_hit` is set. `floor_hit` stays set until the next search starts.
- R7: After a search has ended, strobes leave `gain_code`, `search_done` and `floor_hit` unchanged until the next rising edge of `rx_en`.
- R8: While `rx_en` is low, the search is abandoned. In the next cycle `gain_code` is unchanged, `search_done` is 0, and strobes are ignored.
- R9: A sample exactly equal to `cfg_sat_thr` counts as saturated.
- R10: Outside a search start, `gain_code` never changes except by a single decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; a rising edge starts a search |
| rssi_data | input | RSSI_W | Digitized signal-strength sample |
| rssi_vld | input | 1 | Sample strobe |
| cfg_sat_thr | input | RSSI_W | Saturation threshold; samples at or above it are saturated |
| cfg_settle | input | SETTLE_W | Settling time after a gain step, in cycles (plus one) |
| gain_code | output | GAIN_W | Amplifier gain code; all ones is maximum gain |
| search_done | output | 1 | One-cycle pulse when a search ends |
| floor_hit | output | 1 | Sticky flag: saturation remained at gain code 0 |

## Verification
Several input patterns are used, and each one separates a different kind of fault:
- A constant full-scale input drives the search down to the floor, which exposes faults in the floor path and the sticky flag.
- An input that falls as the gain drops makes the search stop partway down, which exposes step-size and stop-condition faults.
- A gain-dependent input that sits exactly on the threshold at the higher codes separates `>=` from `>`.
- Strobes every cycle against sparse strobes, with settling times of 0 and 7, expose off-by-one errors in the settling window.
- Dropping `rx_en` mid-search, and sending strobes after completion, show whether idle states truly ignore input.

// File: rtl/gbc_pkg.sv
package gbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_SETTLE = 2'd2,
        ST_HOLD   = 2'd3
    } gbc_state_e;

    typedef struct packed {
        logic accept;
        logic saturated;
    } gbc_sample_t;

    typedef struct packed {
        logic restore_max;
        logic step_down;
        logic load_timer;
        logic done_set;
        logic floor_set;
    } gbc_ctrl_t;

    function automatic logic at_or_above(input logic [31:0] level, input logic [31:0] limit);
        return level >= limit;
    endfunction

endpackage

// File: rtl/gbc_rise_det.sv
module gbc_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/gbc_settle_timer.sv
module gbc_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                 remain <= '0;
        else if (load)           remain <= load_val;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/gbc_gain_reg.sv
module gbc_gain_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restore_max,
    input  logic         step_down,
    output logic [W-1:0] gain,
    output logic         at_floor
);
    localparam logic [W-1:0] GAIN_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                          gain <= GAIN_MAX;
        else if (restore_max)             gain <= GAIN_MAX;
        else if (step_down && !at_floor)  gain <= gain - 1'b1;
    end

    assign at_floor = (gain == '0);
endmodule

// File: rtl/gain_backoff_ctrl.sv
module gain_backoff_ctrl
    import gbc_pkg::*;
#(
    parameter int RSSI_W   = 8,
    parameter int SETTLE_W = 8,
    parameter int GAIN_W   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_en,
    input  logic [RSSI_W-1:0]   rssi_data,
    input  logic                rssi_vld,
    input  logic [RSSI_W-1:0]   cfg_sat_thr,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output logic [GAIN_W-1:0]   gain_code,
    output logic                search_done,
    output logic                floor_hit
);
    gbc_state_e  state_q, state_d;
    gbc_sample_t smp;
    gbc_ctrl_t   ctl;
    logic        start;
    logic        settled;
    logic        at_floor;

    gbc_rise_det u_rise (
        .clk   (clk),
        .rst   (rst),
        .level (rx_en),
        .rise  (start)
    );

    gbc_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load_timer),
        .load_val (cfg_settle),
        .expired  (settled)
    );

    gbc_gain_reg #(.W(GAIN_W)) u_gain (
        .clk         (clk),
        .rst         (rst),
        .restore_max (ctl.restore_max),
        .step_down   (ctl.step_down),
        .gain        (gain_code),
        .at_floor    (at_floor)
    );

    always_comb begin
        smp.accept    = (state_q == ST_SAMPLE) && rssi_vld;
        smp.saturated = at_or_above(32'(rssi_data), 32'(cfg_sat_thr));
    end

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        if (start) begin
            state_d         = ST_SAMPLE;
            ctl.restore_max = 1'b1;
        end else if (!rx_en) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_SAMPLE: begin
                    if (smp.accept) begin
                        if (smp.saturated && !at_floor) begin
                            ctl.step_down  = 1'b1;
                            ctl.load_timer = 1'b1;
                            state_d        = ST_SETTLE;
                        end else begin
                            ctl.done_set  = 1'b1;
                            ctl.floor_set = smp.saturated;
                            state_d       = ST_HOLD;
                        end
                    end
                end
                ST_SETTLE: if (settled) state_d = ST_SAMPLE;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            search_done <= 1'b0;
            floor_hit   <= 1'b0;
        end else begin
            state_q     <= state_d;
            search_done <= ctl.done_set;
            if (ctl.restore_max)    floor_hit <= 1'b0;
            else if (ctl.floor_set) floor_hit <= 1'b1;
        end
    end
endmodule

// File: rtl/gbc_checker.sv
module gbc_checker #(
    parameter int SETTLE_W = 8,
    parameter int GAIN_W   = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                rx_en,
    input logic [SETTLE_W-1:0] cfg_settle,
    input logic [GAIN_W-1:0]   gain_code,
    input logic                search_done,
    input logic                floor_hit
);
    logic              en_q;
    logic [GAIN_W-1:0] gain_q;
    logic [SETTLE_W:0] gap;
    logic              last_dec;
    logic              changed, dec_now;

    assign changed = (gain_code != gain_q);
    assign dec_now = changed && (gain_q != '0) && (gain_code == gain_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            gain_q   <= '1;
            gap      <= '0;
            last_dec <= 1'b0;
        end else begin
            en_q   <= rx_en;
            gain_q <= gain_code;
            if (changed) begin
                gap      <= '0;
                last_dec <= dec_now;
            end else if (gap != '1) begin
                gap <= gap + 1'b1;
            end
        end
    end

    AST_RESTART_MAX: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !en_q) |=> (gain_code == '1 && !floor_hit)); // R2

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        !(rx_en && !en_q) |=> (gain_code == $past(gain_code) ||
                              ($past(gain_code) != '0 && gain_code == $past(gain_code) - 1'b1))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        search_done |=> !search_done); // R5

    AST_FLOOR_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        floor_hit |-> (gain_code == '0)); // R6

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        (dec_now && last_dec) |-> (gap >= {1'b0, cfg_settle} + 1'b1)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!search_done && $stable(gain_code))); // R8
endmodule

bind gain_backoff_ctrl gbc_checker #(.SETTLE_W(SETTLE_W), .GAIN_W(GAIN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .cfg_settle  (cfg_settle),
    .gain_code   (gain_code),
    .search_done (search_done),
    .floor_hit   (floor_hit)
);

// File: tb/tb_gain_backoff_ctrl.sv
`timescale 1ns/1ps
module tb_gain_backoff_ctrl;
    localparam int RSSI_W = 8;
    localparam int SETTLE_W = 8;
    localparam int GAIN_W = 3;

    logic clk = 1'b0;
    logic rst;
    logic rx_en;
    logic [RSSI_W-1:0] rssi_data;
    logic rssi_vld;
    logic [RSSI_W-1:0] cfg_sat_thr;
    logic [SETTLE_W-1:0] cfg_settle;
    logic [GAIN_W-1:0] gain_code;
    logic search_done, floor_hit;

    always #2.5 clk = ~clk;

    gain_backoff_ctrl #(.RSSI_W(RSSI_W), .SETTLE_W(SETTLE_W), .GAIN_W(GAIN_W)) dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rssi_data(rssi_data), .rssi_vld(rssi_vld),
        .cfg_sat_thr(cfg_sat_thr), .cfg_settle(cfg_settle), .gain_code(gain_code),
        .search_done(search_done), .floor_hit(floor_hit));

    int errors = 0, checks = 0, cyc = 0, done_cnt = 0;
    int mode = 0, const_lvl = 0, vld_period = 1;
    string cur_req = "R1";

    // reference model state
    int m_gain, m_st, m_wait;
    bit m_done, m_floor, m_prev;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int stim_level(int g);
        int v;
        case (mode)
            1: v = 120 + 20 * g;
            2: v = (g >= 5) ? 200 : 199;
            default: v = const_lvl;
        endcase
        return (v > 255) ? 255 : v;
    endfunction

    // behavioural reference: 0 idle, 1 awaiting sample, 2 settling, 3 finished
    always @(posedge clk) begin
        if (rst) begin
            m_gain = 7; m_done = 0; m_floor = 0; m_st = 0; m_prev = 0; m_wait = 0;
        end else begin
            m_done = 0;
            if (rx_en && !m_prev) begin
                m_gain = 7; m_floor = 0; m_st = 1;
            end else if (!rx_en) begin
                m_st = 0;
            end else if (m_st == 1 && rssi_vld) begin
                if (int'(rssi_data) >= int'(cfg_sat_thr) && m_gain > 0) begin
                    m_gain = m_gain - 1; m_wait = int'(cfg_settle) + 1; m_st = 2;
                end else begin
                    m_done = 1;
                    if (int'(rssi_data) >= int'(cfg_sat_thr)) m_floor = 1;
                    m_st = 3;
                end
            end else if (m_st == 2) begin
                m_wait = m_wait - 1;
                if (m_wait == 0) m_st = 1;
            end
            m_prev = rx_en;
        end
    end

    // compare on every cycle, then drive the sample inputs
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            check({cur_req, " gain"}, int'(gain_code), m_gain);
            check({cur_req, " done"}, int'(search_done), int'(m_done));
            check({cur_req, " floor"}, int'(floor_hit), int'(m_floor));
            if (search_done) done_cnt++;
        end
        rssi_data <= RSSI_W'(stim_level(int'(gain_code)));
        rssi_vld  <= ((cyc % vld_period) == 0);
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk); rx_en = 1'b0;
        wait_cyc(2);
        rx_en = 1'b1;
        @(negedge clk); #1;
        check("R2 restart gain", int'(gain_code), 7);
        check("R2 restart floor", int'(floor_hit), 0);
    endtask

    initial begin
        rst = 1'b1; rx_en = 1'b0; rssi_data = '0; rssi_vld = 1'b0;
        cfg_sat_thr = 8'd200; cfg_settle = 8'd3;
        wait_cyc(3); #1;
        check("R1 reset gain", int'(gain_code), 7);
        check("R1 reset done", int'(search_done), 0);
        check("R1 reset floor", int'(floor_hit), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;
        check("R1 post-reset gain", int'(gain_code), 7);

        // constant full scale: search to floor
        cur_req = "R6"; mode = 0; const_lvl = 255; vld_period = 1;
        rx_en = 1'b1;
        wait_cyc(60); #1;
        check("R6 floor gain", int'(gain_code), 0);
        check("R6 floor flag", int'(floor_hit), 1);
        check("R6 single done", done_cnt, 1);

        // strobes after completion
        cur_req = "R7";
        wait_cyc(20); #1;
        check("R7 gain held", int'(gain_code), 0);
        check("R7 no extra done", done_cnt, 1);

        // receiver off with strobes present
        cur_req = "R8";
        @(negedge clk); rx_en = 1'b0;
        wait_cyc(10); #1;
        check("R8 idle gain held", int'(gain_code), 0);
        check("R8 idle floor held", int'(floor_hit), 1);

        // falling response: stops partway
        cur_req = "R3"; mode = 1;
        restart();
        wait_cyc(60); #1;
        check("R3 stop gain", int'(gain_code), 3);
        check("R5 stop done", done_cnt, 2);
        check("R5 no floor", int'(floor_hit), 0);

        // equality with threshold counts as saturated
        cur_req = "R9"; mode = 2;
        restart();
        wait_cyc(60); #1;
        check("R9 equal saturates", int'(gain_code), 4);

        // sparse strobes, long settle
        cur_req = "R4"; mode = 1; vld_period = 5; cfg_settle = 8'd7;
        restart();
        wait_cyc(150); #1;
        check("R4 sparse stop gain", int'(gain_code), 3);

        // zero settle, strobes every cycle
        cur_req = "R4 zero settle"; vld_period = 1; cfg_settle = 8'd0;
        restart();
        wait_cyc(40); #1;
        check("R4 zero settle gain", int'(gain_code), 3);

        // abort mid-search
        cur_req = "R8 abort"; mode = 0; const_lvl = 255; cfg_settle = 8'd10;
        begin
            int g0, d0;
            restart();
            wait_cyc(15);
            rx_en = 1'b0;
            @(negedge clk); #1;
            g0 = int'(gain_code); d0 = done_cnt;
            wait_cyc(20); #1;
            check("R8 abort gain held", int'(gain_code), g0);
            check("R8 abort no done", done_cnt, d0);
            check("R10 abort mid-range", int'(g0 > 0 && g0 < 7), 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule